// File: doc/BRIEF.md
# Power-Rail Mode and Sequencing Controller

This controller decides when each of four output power rails is switched on, and it tracks whether the supply is asleep, idle or running. A wake pin, four per-rail request pins, two one-shot software commands and four fault flags drive it. A set of sequence-slot values and an inter-step delay, both writable while awake, set the order in which rails switch during sequenced transitions. Rail enables go to the regulators. A mode code and a one-cycle register-reset pulse go to the surrounding configuration logic.

The block has three externally visible modes. In sleep, every rail is off and the configuration is held at its defaults. In standby, the block is awake and every rail is off. In active, at least one rail is on and no fault is present. Pin-driven changes act on single rails as their request pins toggle. Sequenced changes walk the sequence slots one step at a time. A power-up step goes upward through the slots. A power-down step goes downward through the slots.

The wake pin and the request pins are asynchronous and pass through two-flop synchronizers. The fault flags and the command strobes are taken as synchronous. All interfaces are plain level or pulse pins, so there is no streaming interface and no back-pressure.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset the mode is sleep (mode code 0), all rail enables are 0 and the register-reset pulse is 0.
- R2: While in sleep, configuration writes are ignored and the configuration is held at its defaults: rail i in slot i, delay DEF_DLY. Each entry into sleep from another mode gives exactly one cycle of reg_rst_o high.
- R3: A wake rise while any request pin is high and no fault is present starts a power-up of exactly those requested rails. The mode becomes active (code 2). Slot k switches on (DLY+1)*k cycles after slot 0.
- R4: A wake rise with all request pins low enters standby (code 1), with every rail off.
- R5: In active, a request rising edge turns on its rail and a request falling edge turns it off. When the last enabled rail is turned off this way, the mode becomes standby.
- R6: In standby with wake high and no fault, a request rising edge enters active with that rail on. Rails come on in the order their pins rose.
- R7: An ACTIVE command in standby powers all rails up in ascending slot order, with DLY+1 cycles between slots.
- R8: The block reaches sleep with every rail off in two cases. With wake low in active, the rails first go off in descending slot order. With wake low in standby, it goes to sleep directly.
- R9: A fault (thermal, input UVLO, positive UV or negative UV) or a STANDBY command in active turns the rails off in descending slot order, then enters standby. No rail turns on during a power-down.
- R10: A fault during a power-up aborts it. No further rail turns on from the cycle the fault is seen, and power-down begins.
- R11: While a fault is present, request edges and the ACTIVE command do not move the block out of standby.
- R12: A request pin change reaches the rail enables on the third rising clock edge after the change, not earlier.
- R13: Rails that share a slot switch in the same cycle. A delay of 0 makes successive slots fire on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_i | input | 1 | Wake pin, asynchronous |
| req_i | input | N_RAIL | Per-rail request pins, asynchronous |
| cmd_active_i | input | 1 | One-cycle strobe: sequenced power-up of all rails |
| cmd_standby_i | input | 1 | One-cycle strobe: sequenced power-down to standby |
| therm_sd_i | input | 1 | Thermal shutdown flag |
| in_uvlo_i | input | 1 | Input undervoltage lockout flag |
| pos_uv_i | input | 1 | Positive rail undervoltage flag |
| neg_uv_i | input | 1 | Negative rail undervoltage flag |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_slot_i | input | N_RAIL*SLOT_W | Slot per rail, rail i at bits [i*SLOT_W +: SLOT_W] |
| cfg_dly_i | input | DLY_W | Inter-step delay in cycles |
| rail_en_o | output | N_RAIL | Rail enables |
| mode_o | output | 2 | 0 sleep, 1 standby, 2 active |
| reg_rst_o | output | 1 | One-cycle pulse on entry into sleep |

## Verification
The bench measures the spacing between rail switching times, so it catches three kinds of error: a reversed or skipped slot walk, a delay off by one, and a shutdown that runs the power-up order. It also writes a reversed slot map while the block is asleep. A design that lets that write through would bring the rails up backwards. The bench raises a fault partway through a power-up. A design that finishes the step in progress, or ignores the abort, shows one more rail turning on. Fault priority and sync latency are each tested on a single cycle. A design that lets a request edge through during a fault would leave standby. A design with one synchronizer flop too few would switch a rail one cycle early.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP   = 2'd0,
    MODE_STANDBY = 2'd1,
    MODE_ACTIVE  = 2'd2
  } pwr_mode_e;

  typedef enum logic [2:0] {
    ST_SLEEP,
    ST_STBY,
    ST_ACT,
    ST_UP,
    ST_DN
  } pwr_state_e;
endpackage

// File: rtl/pwr_pin_sync.sv
module pwr_pin_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign lvl_o  = sync_q;
  assign rise_o = sync_q & ~last_q;
  assign fall_o = ~sync_q & last_q;
endmodule

// File: rtl/pwr_seq_stepper.sv
module pwr_seq_stepper #(
  parameter int SLOT_W = 2,
  parameter int DLY_W  = 8,
  parameter int LAST   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              up_i,
  input  logic [DLY_W-1:0]  dly_i,
  output logic              fire_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              last_o
);
  localparam logic [SLOT_W-1:0] TOP = SLOT_W'(LAST);

  logic              run_q, up_q, at_end;
  logic [SLOT_W-1:0] cur_q;
  logic [DLY_W-1:0]  cnt_q;

  assign fire_o = run_q && (cnt_q == '0);
  assign at_end = up_q ? (cur_q == TOP) : (cur_q == '0);
  assign last_o = fire_o && at_end;
  assign slot_o = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      up_q  <= 1'b0;
      cur_q <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      up_q  <= up_i;
      cur_q <= up_i ? '0 : TOP;
      cnt_q <= '0;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        if (at_end) begin
          run_q <= 1'b0;
        end else begin
          cur_q <= up_q ? cur_q + 1'b1 : cur_q - 1'b1;
          cnt_q <= dly_i;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  AST_SLOT_HELD_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q != '0 && !start_i) |=> $stable(cur_q)); // R3
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int N_RAIL  = 4,
  parameter int SLOT_W  = (N_RAIL > 1) ? $clog2(N_RAIL) : 1,
  parameter int DLY_W   = 8,
  parameter int DEF_DLY = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wake_i,
  input  logic [N_RAIL-1:0]        req_i,
  input  logic                     cmd_active_i,
  input  logic                     cmd_standby_i,
  input  logic                     therm_sd_i,
  input  logic                     in_uvlo_i,
  input  logic                     pos_uv_i,
  input  logic                     neg_uv_i,
  input  logic                     cfg_we_i,
  input  logic [N_RAIL*SLOT_W-1:0] cfg_slot_i,
  input  logic [DLY_W-1:0]         cfg_dly_i,
  output logic [N_RAIL-1:0]        rail_en_o,
  output logic [1:0]               mode_o,
  output logic                     reg_rst_o
);
  localparam int CFG_W = N_RAIL * SLOT_W;
  localparam logic [DLY_W-1:0] DLY_RST = DLY_W'(DEF_DLY);

  function automatic logic [CFG_W-1:0] slot_defaults();
    logic [CFG_W-1:0] v;
    for (int i = 0; i < N_RAIL; i++) v[i*SLOT_W +: SLOT_W] = SLOT_W'(i);
    return v;
  endfunction
  localparam logic [CFG_W-1:0] SLOT_RST = slot_defaults();

  pwr_state_e state_q, state_d;
  logic [N_RAIL-1:0] rail_q, rail_d, mask_q, mask_d, sel;
  logic [CFG_W-1:0]  slot_q;
  logic [DLY_W-1:0]  dly_q;
  logic act_q, stby_q, rst_pulse_q, fault;
  logic go_up, go_dn, fire, last_step;
  logic [SLOT_W-1:0] step_slot;
  logic [N_RAIL:0] p_lvl, p_rise, p_fall;
  logic wake_lvl, wake_rise, wake_fall;
  logic [N_RAIL-1:0] req_lvl, req_rise, req_fall;

  pwr_pin_sync #(.W(N_RAIL + 1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({wake_i, req_i}),
    .lvl_o(p_lvl), .rise_o(p_rise), .fall_o(p_fall)
  );
  assign {wake_lvl, req_lvl}   = p_lvl;
  assign {wake_rise, req_rise} = p_rise;
  assign {wake_fall, req_fall} = p_fall;

  pwr_seq_stepper #(.SLOT_W(SLOT_W), .DLY_W(DLY_W), .LAST(N_RAIL - 1)) u_step (
    .clk(clk), .rst_n(rst_n), .start_i(go_up || go_dn), .up_i(go_up),
    .dly_i(dly_q), .fire_o(fire), .slot_o(step_slot), .last_o(last_step)
  );

  for (genvar g = 0; g < N_RAIL; g++) begin : g_sel
    assign sel[g] = (slot_q[g*SLOT_W +: SLOT_W] == step_slot);
  end

  assign fault = therm_sd_i | in_uvlo_i | pos_uv_i | neg_uv_i;

  always_comb begin
    state_d = state_q;
    rail_d  = rail_q;
    mask_d  = mask_q;
    go_up   = 1'b0;
    go_dn   = 1'b0;
    unique case (state_q)
      ST_SLEEP: if (wake_rise) begin
        if (|req_lvl && !fault) begin
          state_d = ST_UP;
          go_up   = 1'b1;
          mask_d  = req_lvl;
        end else begin
          state_d = ST_STBY;
        end
      end
      ST_STBY: begin
        if (wake_fall || !wake_lvl) begin
          state_d = ST_SLEEP;
        end else if (!fault) begin
          if (|req_rise) begin
            state_d = ST_ACT;
            rail_d  = req_rise;
          end else if (act_q) begin
            state_d = ST_UP;
            go_up   = 1'b1;
            mask_d  = '1;
          end
        end
      end
      ST_ACT: begin
        if (fault || stby_q || !wake_lvl) begin
          state_d = ST_DN;
          go_dn   = 1'b1;
        end else begin
          rail_d = (rail_q | req_rise) & ~req_fall;
          if (rail_d == '0) state_d = ST_STBY;
        end
      end
      ST_UP: begin
        if (fault || stby_q || !wake_lvl) begin
          state_d = ST_DN;
          go_dn   = 1'b1;
        end else if (fire) begin
          rail_d = rail_q | (sel & mask_q);
          if (last_step) state_d = ST_ACT;
        end
      end
      ST_DN: if (fire) begin
        rail_d = rail_q & ~sel;
        if (last_step) state_d = wake_lvl ? ST_STBY : ST_SLEEP;
      end
      default: state_d = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_SLEEP;
      rail_q      <= '0;
      mask_q      <= '0;
      act_q       <= 1'b0;
      stby_q      <= 1'b0;
      rst_pulse_q <= 1'b0;
      slot_q      <= SLOT_RST;
      dly_q       <= DLY_RST;
    end else begin
      state_q     <= state_d;
      rail_q      <= rail_d;
      mask_q      <= mask_d;
      act_q       <= cmd_active_i && (state_q != ST_SLEEP);
      stby_q      <= cmd_standby_i && (state_q != ST_SLEEP);
      rst_pulse_q <= (state_d == ST_SLEEP) && (state_q != ST_SLEEP);
      if (state_q == ST_SLEEP) begin
        slot_q <= SLOT_RST;
        dly_q  <= DLY_RST;
      end else if (cfg_we_i) begin
        slot_q <= cfg_slot_i;
        dly_q  <= cfg_dly_i;
      end
    end
  end

  assign rail_en_o = rail_q;
  assign reg_rst_o = rst_pulse_q;
  assign mode_o    = (state_q == ST_SLEEP) ? MODE_SLEEP :
                     (state_q == ST_STBY)  ? MODE_STANDBY : MODE_ACTIVE;

  AST_SLEEP_RAILS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_SLEEP) |-> (rail_en_o == '0)); // R8
  AST_STBY_RAILS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_STANDBY) |-> (rail_en_o == '0)); // R4
  AST_FAULT_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> ((rail_en_o & ~$past(rail_en_o)) == '0)); // R10
  AST_DOWN_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DN) |=> ((rail_en_o & ~$past(rail_en_o)) == '0)); // R9
  AST_CFG_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && $past(state_q) == ST_SLEEP) |-> (slot_q == SLOT_RST && dly_q == DLY_RST)); // R2
  AST_RST_PULSE_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rst_o |-> (mode_o == MODE_SLEEP && $past(mode_o) != MODE_SLEEP)); // R2
endmodule

// File: tb/tb_pwr_seq_ctrl.sv
module tb_pwr_seq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wake = 1'b0;
  logic [3:0] req = '0;
  logic cmd_act = 1'b0, cmd_stby = 1'b0;
  logic tsd = 1'b0, uvlo = 1'b0, puv = 1'b0, nuv = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_slot = '0;
  logic [7:0] cfg_dly = '0;
  logic [3:0] rail_en;
  logic [1:0] mode;
  logic reg_rst;

  int checks = 0, errors = 0;
  bit done = 0;
  int cyc = 0, rises = 0, pulses = 0;
  int on_t[4], off_t[4];
  logic [3:0] prev_en = '0;

  // {req[3:0], expected rails[3:0], expected mode[1:0]}
  localparam logic [9:0] VEC [9] = '{
    10'b0001_0001_10, 10'b0011_0011_10, 10'b0111_0111_10,
    10'b0101_0101_10, 10'b0100_0100_10, 10'b0000_0000_01,
    10'b1000_1000_10, 10'b1001_1001_10, 10'b0000_0000_01
  };

  always #2.5 clk = ~clk;

  pwr_seq_ctrl #(.N_RAIL(4), .DLY_W(8), .DEF_DLY(3)) dut (
    .clk(clk), .rst_n(rst_n), .wake_i(wake), .req_i(req),
    .cmd_active_i(cmd_act), .cmd_standby_i(cmd_stby),
    .therm_sd_i(tsd), .in_uvlo_i(uvlo), .pos_uv_i(puv), .neg_uv_i(nuv),
    .cfg_we_i(cfg_we), .cfg_slot_i(cfg_slot), .cfg_dly_i(cfg_dly),
    .rail_en_o(rail_en), .mode_o(mode), .reg_rst_o(reg_rst)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int i = 0; i < 4; i++) begin
      if (rail_en[i] && !prev_en[i]) on_t[i] <= cyc;
      if (!rail_en[i] && prev_en[i]) off_t[i] <= cyc;
    end
    rises <= rises + $countones(rail_en & ~prev_en);
    if (reg_rst) pulses <= pulses + 1;
    prev_en <= rail_en;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse_cmd(input bit stby);
    if (stby) cmd_stby = 1'b1; else cmd_act = 1'b1;
    tick(1);
    cmd_act = 1'b0;
    cmd_stby = 1'b0;
  endtask

  task automatic write_cfg(input logic [7:0] s, input logic [7:0] d);
    cfg_we = 1'b1; cfg_slot = s; cfg_dly = d;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic summary();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int p0, snap, n;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk("R1 mode", mode, 0);
    chk("R1 rails", rail_en, 0);
    chk("R1 reg_rst", reg_rst, 0);

    // write in sleep must be dropped: reversed slots, zero delay
    write_cfg(8'h1B, 8'd0);
    req = 4'b0101; wake = 1'b1;
    tick(40);
    chk("R3 rails masked", rail_en, 4'b0101);
    chk("R3 mode", mode, 2);
    chk("R2 default order/delay", on_t[2] - on_t[0], 8);

    p0 = pulses;
    wake = 1'b0;
    tick(40);
    chk("R8 mode sleep", mode, 0);
    chk("R8 rails off", rail_en, 0);
    chk("R8 descending off", off_t[0] - off_t[2], 8);
    chk("R2 one pulse", pulses - p0, 1);

    req = 4'b0000; wake = 1'b1;
    tick(10);
    chk("R4 mode standby", mode, 1);
    chk("R4 rails off", rail_en, 0);

    // sync latency
    req = 4'b0001;
    tick(2);
    chk("R12 not early", rail_en[0], 0);
    tick(1);
    chk("R12 on third edge", rail_en[0], 1);
    req = 4'b0000;
    tick(6);

    for (int v = 0; v < 9; v++) begin
      req = VEC[v][9:6];
      tick(6);
      chk($sformatf("R5/R6 vec%0d rails", v), rail_en, VEC[v][5:2]);
      chk($sformatf("R5/R6 vec%0d mode", v), mode, VEC[v][1:0]);
    end

    write_cfg(8'h1B, 8'd5);
    pulse_cmd(1'b0);
    tick(40);
    chk("R7 all on", rail_en, 4'hF);
    chk("R7 ascending slots", on_t[0] - on_t[3], 18);

    pulse_cmd(1'b1);
    tick(40);
    chk("R9 cmd standby mode", mode, 1);
    chk("R9 descending off", off_t[3] - off_t[0], 18);

    // fault during power-up
    pulse_cmd(1'b0);
    n = 0;
    while ($countones(rail_en) < 2 && n < 100) begin tick(1); n++; end
    snap = rises;
    nuv = 1'b1;
    tick(1);
    nuv = 1'b0;
    tick(40);
    chk("R10 no further rise", rises - snap, 0);
    chk("R10 rails off", rail_en, 0);
    chk("R10 mode standby", mode, 1);

    req = 4'hF;
    tick(6);
    chk("R6 all rise together", rail_en, 4'hF);
    tsd = 1'b1;
    tick(1);
    tsd = 1'b0;
    tick(40);
    chk("R9 fault standby", mode, 1);
    chk("R9 fault reverse order", off_t[3] - off_t[0], 18);
    req = 4'h0;
    tick(6);

    uvlo = 1'b1;
    req = 4'b0010;
    tick(6);
    pulse_cmd(1'b0);
    tick(30);
    chk("R11 held in standby", mode, 1);
    chk("R11 rails off", rail_en, 0);
    uvlo = 1'b0;
    req = 4'b0000;
    tick(6);

    write_cfg(8'h00, 8'd0);
    pulse_cmd(1'b0);
    tick(10);
    chk("R13 all on", rail_en, 4'hF);
    chk("R13 same cycle", on_t[3] - on_t[0], 0);

    p0 = pulses;
    wake = 1'b0;
    tick(20);
    chk("R8 active to sleep", mode, 0);
    wake = 1'b1;
    tick(10);
    chk("R4 wake to standby", mode, 1);
    wake = 1'b0;
    tick(10);
    chk("R8 standby to sleep", mode, 0);
    chk("R2 two pulses", pulses - p0, 2);

    summary();
  end
endmodule